// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This unit belongs to one DMA channel. It walks a chain of command descriptors held in memory and loads each one into the channel's working registers before running it. Software first writes the address of the first descriptor into the list-node register. It then writes the control register with the list-enable bit set. The unit reads the eight-word descriptor through a simple word-read memory port. When the last word is in, it commits all eight words at once. It then drives a simplified transfer engine that moves at most one bus-width beat per cycle until the byte count is used up.

The descriptor image uses the same layout as the channel's register window, so committing a descriptor overwrites the working registers with the same meaning. After a descriptor completes, the unit follows its next-node word. A zero next-node word ends the walk. A pointer back to an earlier node makes the walk run until software cancels it.

A one-cycle event pulse tells software about progress. The first pulse after a start means the list has been loaded. Every later pulse means one descriptor has finished. A size field of all ones is reserved. Because of that, the remaining-size readback can always tell "nothing left" apart from a real count.

Top module: `dma_ll_walker`

## Requirements
- R1: After reset the unit is idle. memReq, beatValid and evtPulse are low, and reading offset 0x30 returns 0x00FFFFFF.
- R2: While idle, a write to offset 0x1C with bit 4 set and bit 20 clear starts a fetch from the address held at offset 0x14. memReq rises the next cycle. The eight words are read at node, node+4, … node+28 in that order. memAddr advances by 4 only after memAck accepts a word.
- R3: The fetched words 0..7 replace the registers at offsets 0x00, 0x04, … 0x1C together, in the cycle after the eighth word is accepted. Before that, reading those offsets returns the old values. Bits 23:0 of word 4 give the byte count minus one.
- R4: The first descriptor committed after a start raises evtPulse for one cycle. This is the cycle after its eighth word is accepted.
- R5: From the cycle after commit, beatValid is high on every cycle until the count is used up. Each beat carries min(remaining, BUS_BYTES) bytes, so the beats add up to size+1 bytes. beatRdAddr is the value at offset 0x08 and beatWrAddr is the value at offset 0x0C. Each of these steps by BUS_BYTES after every beat, but only if bit 8 (read) or bit 12 (write) of offset 0x00 is set.
- R6: Every descriptor raises evtPulse for one cycle in the cycle after its final beat.
- R7: The next fetch starts only after the final beat; memReq is high in the following cycle. The fetch address is the committed next-node word at offset 0x14. If that word is zero, the unit goes idle. A next-node word that points back to an earlier node repeats the chain.
- R8: Reading offset 0x30 returns the remaining byte count minus one while bytes remain. Otherwise it returns 0x00FFFFFF. Offsets with nothing behind them read zero.
- R9: A descriptor whose size field is 0xFFFFFF moves no beats. Its completion pulse comes one cycle after commit.
- R10: A write to offset 0x1C with bit 20 set returns the unit to idle in the next cycle, from either fetching or running. It produces no completion pulse and no further beat or read. A descriptor that was only partly fetched is dropped, and the working registers keep their old values.
- R11: While the unit is fetching or running, register writes are ignored, except for the cancel bit of offset 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte offset of the write in the channel window |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 6 | Byte offset of the combinational read |
| regRdData | output | 32 | Read data |
| memReq | output | 1 | Descriptor word read request |
| memAddr | output | 32 | Byte address of the requested word |
| memAck | input | 1 | Request accepted; memRdData is valid in the same cycle |
| memRdData | input | 32 | Descriptor word |
| beatValid | output | 1 | A transfer beat happens this cycle |
| beatRdAddr | output | 32 | Source address of the beat |
| beatWrAddr | output | 32 | Destination address of the beat |
| beatBytes | output | BYTES_W | Bytes moved by the beat |
| evtPulse | output | 1 | One-cycle load or completion event |

## Verification
The bench goes after the following corner cases.

- **Uneven last beat.** It runs byte counts that do not end on a full beat. A design that rounded the count would send an extra beat or get beatBytes wrong.
- **Reserved size.** It places a reserved-size descriptor in the middle of a chain. A design that decoded 0xFFFFFF as a real count would stream about sixteen million bytes and the watchdog would expire.
- **Ring of two nodes.** It runs a two-node ring with memAck held back on some cycles. A design that dropped the ring back-pointer would stop. A design that advanced memAddr without an accept would load shifted words.
- **Cancel mid-fetch.** It cancels during a fetch. A design that wrote fetched words straight into the working registers would show a mixed descriptor when they are read back.
- **Writes while busy.** It writes registers while a descriptor runs. A design that accepted those writes would start fetching from the new node address.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int SIZE_W     = 24;

  // word slots inside the channel window / descriptor image
  localparam int W_GEN   = 0;
  localparam int W_RADDR = 2;
  localparam int W_WADDR = 3;
  localparam int W_SIZE  = 4;
  localparam int W_NODE  = 5;

  localparam logic [5:0] OFS_CTRL   = 6'h1C;
  localparam logic [5:0] OFS_ACTIVE = 6'h30;

  localparam int BIT_LIST_EN = 4;
  localparam int BIT_CANCEL  = 20;
  localparam int BIT_INC_RD  = 8;
  localparam int BIT_INC_WR  = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } llState_t;

  typedef struct packed {
    logic cfgWrite;    // idle-time register write allowed
    logic startFetch;  // restart word index at the node pointer
    logic wordTake;    // a descriptor word is accepted this cycle
    logic commit;      // last word accepted, load working registers
    logic beatStep;    // run one step of the transfer counter
    logic cancel;      // abort, clear the counter
    logic fetching;    // level: fetch state
  } llStrobe_t;

endpackage

// File: rtl/dma_ll_ctrl.sv
module dma_ll_ctrl
  import dma_ll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      ctrlHit,
  input  logic      startBit,
  input  logic      cancelBit,
  input  logic      memAck,
  input  logic      lastWord,
  input  logic      lastBeat,
  input  logic      nextZero,
  output llStrobe_t strb,
  output logic      memReq,
  output logic      evtPulse
);

  llState_t state, nextState;
  logic     firstDesc;
  logic     loadEvt, doneEvt;
  logic     cancelReq, startReq;

  assign cancelReq = ctrlHit && cancelBit;
  assign startReq  = ctrlHit && startBit;
  assign memReq    = (state == ST_FETCH);

  always_comb begin
    strb      = '0;
    nextState = state;
    loadEvt   = 1'b0;
    doneEvt   = 1'b0;
    strb.fetching = (state == ST_FETCH);
    case (state)
      ST_IDLE: begin
        strb.cfgWrite = regWrEn;
        if (cancelReq) begin
          strb.cancel = 1'b1;
        end else if (startReq) begin
          strb.startFetch = 1'b1;
          nextState       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (cancelReq) begin
          strb.cancel = 1'b1;
          nextState   = ST_IDLE;
        end else if (memAck) begin
          strb.wordTake = 1'b1;
          if (lastWord) begin
            strb.commit = 1'b1;
            loadEvt     = firstDesc;
            nextState   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (cancelReq) begin
          strb.cancel = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          strb.beatStep = 1'b1;
          if (lastBeat) begin
            doneEvt = 1'b1;
            if (nextZero) begin
              nextState = ST_IDLE;
            end else begin
              strb.startFetch = 1'b1;
              nextState       = ST_FETCH;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstDesc <= 1'b0;
      evtPulse  <= 1'b0;
    end else begin
      state    <= nextState;
      evtPulse <= loadEvt || doneEvt;
      if (strb.startFetch && state == ST_IDLE) begin
        firstDesc <= 1'b1;
      end else if (strb.commit) begin
        firstDesc <= 1'b0;
      end
    end
  end

  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (cancelReq && state != ST_IDLE) |=> (state == ST_IDLE && !evtPulse)); // R10

  AST_EVT_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> ($past(state) != ST_IDLE)); // R6

  AST_START_REQUESTS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && !cancelReq) |=> memReq); // R2

endmodule

// File: rtl/dma_ll_datapath.sv
module dma_ll_datapath
  import dma_ll_pkg::*;
#(
  parameter  int BUS_BYTES = 4,
  localparam int BYTES_W   = $clog2(BUS_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  llStrobe_t          strb,
  input  logic [5:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic [5:0]         regRdAddr,
  input  logic [31:0]        memRdData,
  output logic [31:0]        regRdData,
  output logic [31:0]        memAddr,
  output logic [31:0]        beatRdAddr,
  output logic [31:0]        beatWrAddr,
  output logic [BYTES_W-1:0] beatBytes,
  output logic               beatValid,
  output logic               lastWord,
  output logic               lastBeat,
  output logic               nextZero
);

  localparam logic [SIZE_W-1:0] SIZE_ALL1 = '1;
  localparam logic [SIZE_W-1:0] STEP      = SIZE_W'(BUS_BYTES);

  logic [31:0]       workReg [DESC_WORDS];
  logic [31:0]       shadow  [DESC_WORDS];
  logic [IDX_W-1:0]  wordIdx;
  logic [SIZE_W-1:0] remaining;
  logic [SIZE_W-1:0] loadSize;
  logic [SIZE_W-1:0] activeSize;
  logic              skipDesc;
  logic              cfgHit;
  logic              incRd, incWr;

  assign cfgHit     = strb.cfgWrite && !regAddr[5] && (regAddr[1:0] == 2'b00);
  assign loadSize   = shadow[W_SIZE][SIZE_W-1:0];
  assign incRd      = workReg[W_GEN][BIT_INC_RD];
  assign incWr      = workReg[W_GEN][BIT_INC_WR];
  assign beatValid  = strb.beatStep && !skipDesc;
  assign lastBeat   = skipDesc || (remaining <= STEP);
  assign lastWord   = (wordIdx == IDX_W'(DESC_WORDS - 1));
  assign nextZero   = (workReg[W_NODE] == 32'd0);
  assign memAddr    = workReg[W_NODE] + 32'({wordIdx, 2'b00});
  assign beatRdAddr = workReg[W_RADDR];
  assign beatWrAddr = workReg[W_WADDR];
  assign beatBytes  = (remaining >= STEP) ? BYTES_W'(BUS_BYTES)
                                          : remaining[BYTES_W-1:0];
  assign activeSize = (remaining == '0) ? SIZE_ALL1 : remaining - 1'b1;

  always_comb begin
    if (regRdAddr == OFS_ACTIVE) begin
      regRdData = {{(32 - SIZE_W){1'b0}}, activeSize};
    end else if (!regRdAddr[5] && regRdAddr[1:0] == 2'b00) begin
      regRdData = workReg[regRdAddr[4:2]];
    end else begin
      regRdData = 32'd0;
    end
  end

  // words land here first so a cancelled fetch leaves no trace
  always_ff @(posedge clk) begin
    if (strb.wordTake) begin
      shadow[wordIdx] <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_WORDS; i++) begin
        workReg[i] <= 32'd0;
      end
      wordIdx   <= '0;
      remaining <= '0;
      skipDesc  <= 1'b0;
    end else begin
      if (cfgHit) begin
        workReg[regAddr[4:2]] <= regWrData;
      end
      if (strb.startFetch) begin
        wordIdx <= '0;
      end
      if (strb.wordTake) begin
        wordIdx <= wordIdx + 1'b1;
      end
      if (strb.commit) begin
        for (int i = 0; i < DESC_WORDS - 1; i++) begin
          workReg[i] <= shadow[i];
        end
        workReg[DESC_WORDS-1] <= memRdData;
        skipDesc  <= (loadSize == SIZE_ALL1);
        remaining <= (loadSize == SIZE_ALL1) ? '0 : loadSize + 1'b1;
      end
      if (beatValid) begin
        if (incRd) workReg[W_RADDR] <= workReg[W_RADDR] + 32'(BUS_BYTES);
        if (incWr) workReg[W_WADDR] <= workReg[W_WADDR] + 32'(BUS_BYTES);
      end
      if (strb.beatStep) begin
        remaining <= lastBeat ? '0 : remaining - STEP;
      end
      if (strb.cancel) begin
        remaining <= '0;
        skipDesc  <= 1'b0;
      end
    end
  end

  AST_FETCH_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordTake && !lastWord) |=> (memAddr == $past(memAddr) + 32'd4)); // R2

  AST_RESIDUE_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (activeSize != SIZE_ALL1)); // R8

  AST_FETCH_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetching |-> (remaining == '0)); // R7

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && loadSize == SIZE_ALL1) |=> (activeSize == SIZE_ALL1)); // R9

endmodule

// File: rtl/dma_ll_walker.sv
module dma_ll_walker
  import dma_ll_pkg::*;
#(
  parameter  int BUS_BYTES = 4,
  localparam int BYTES_W   = $clog2(BUS_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [5:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic [5:0]         regRdAddr,
  output logic [31:0]        regRdData,
  output logic               memReq,
  output logic [31:0]        memAddr,
  input  logic               memAck,
  input  logic [31:0]        memRdData,
  output logic               beatValid,
  output logic [31:0]        beatRdAddr,
  output logic [31:0]        beatWrAddr,
  output logic [BYTES_W-1:0] beatBytes,
  output logic               evtPulse
);

  llStrobe_t strb;
  logic      lastWord, lastBeat, nextZero;
  logic      ctrlHit;

  assign ctrlHit = regWrEn && (regAddr == OFS_CTRL);

  dma_ll_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .ctrlHit   (ctrlHit),
    .startBit  (regWrData[BIT_LIST_EN]),
    .cancelBit (regWrData[BIT_CANCEL]),
    .memAck    (memAck),
    .lastWord  (lastWord),
    .lastBeat  (lastBeat),
    .nextZero  (nextZero),
    .strb      (strb),
    .memReq    (memReq),
    .evtPulse  (evtPulse)
  );

  dma_ll_datapath #(.BUS_BYTES(BUS_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdAddr  (regRdAddr),
    .memRdData  (memRdData),
    .regRdData  (regRdData),
    .memAddr    (memAddr),
    .beatRdAddr (beatRdAddr),
    .beatWrAddr (beatWrAddr),
    .beatBytes  (beatBytes),
    .beatValid  (beatValid),
    .lastWord   (lastWord),
    .lastBeat   (lastBeat),
    .nextZero   (nextZero)
  );

endmodule

// File: tb/dma_ll_walker_bench.sv
module dma_ll_walker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BB         = 4;
  localparam int BW         = $clog2(BB) + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [5:0]    regAddr = 6'h0;
  logic [31:0]   regWrData = 32'h0;
  logic [5:0]    regRdAddr = 6'h30;
  logic [31:0]   regRdData;
  logic          memReq;
  logic [31:0]   memAddr;
  logic          memAck = 1'b0;
  logic [31:0]   memRdData = 32'h0;
  logic          beatValid;
  logic [31:0]   beatRdAddr, beatWrAddr;
  logic [BW-1:0] beatBytes;
  logic          evtPulse;

  int testCnt = 0;
  int failCnt = 0;
  int ackMode = 0;
  int ackPhase = 0;
  int beatCnt = 0, byteSum = 0, evtCnt = 0, headFetch = 0, badFetch = 0;

  logic [31:0] memImg [int unsigned];

  // reference model state
  int          mState = 0, mIdx = 0, mRem = 0;
  bit          mSkip = 0, mFirst = 0, mEvt = 0;
  logic [31:0] mRegs [8];
  logic [31:0] mShadow [8];
  logic [31:0] mFptr = 32'h0;

  dma_ll_walker #(.BUS_BYTES(BB)) u_dma_ll_walker (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdData(memRdData),
    .beatValid(beatValid), .beatRdAddr(beatRdAddr), .beatWrAddr(beatWrAddr),
    .beatBytes(beatBytes), .evtPulse(evtPulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memImg.exists(a)) return memImg[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    if (a == 6'h30) return (mRem == 0) ? 32'h00FF_FFFF : 32'(mRem - 1);
    if (a < 6'h20 && a[1:0] == 2'b00) return mRegs[a >> 2];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic putDesc(input logic [31:0] base, input logic [31:0] gen,
                         input logic [31:0] src, input logic [31:0] dst,
                         input logic [31:0] size, input logic [31:0] nxt);
    memImg[base]      = gen;
    memImg[base + 4]  = 32'h0000_0005;
    memImg[base + 8]  = src;
    memImg[base + 12] = dst;
    memImg[base + 16] = size;
    memImg[base + 20] = nxt;
    memImg[base + 24] = 32'h0;
    memImg[base + 28] = 32'h0000_0011;
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 32'h0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    regRdAddr = a;
    #2;
    v = regRdData;
    @(negedge clk);
    regRdAddr = 6'h30;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((mState != 0 || mEvt) && n < 20000);
    @(negedge clk);
    if (n >= 20000) check(1'b0, "R7 idle timeout", 32'(mState), 32'h0);
  endtask

  // memory responder
  always @(negedge clk) begin
    ackPhase++;
    case (ackMode)
      0:       memAck = 1'b1;
      1:       memAck = (ackPhase % 3) != 1;
      default: memAck = 1'b0;
    endcase
    memRdData = memRead(memAddr);
  end

  // reference model update
  always @(posedge clk) begin
    bit cancelIn, startIn, evtN, last;
    int sz, bytes;
    cancelIn = regWrEn && regAddr == 6'h1C && regWrData[20];
    startIn  = regWrEn && regAddr == 6'h1C && regWrData[4];
    evtN = 1'b0;
    if (!rstN) begin
      mState = 0; mIdx = 0; mRem = 0; mSkip = 0; mFirst = 0; mEvt = 0;
      for (int k = 0; k < 8; k++) mRegs[k] = 32'h0;
    end else begin
      case (mState)
        0: begin
          if (regWrEn && regAddr < 6'h20 && regAddr[1:0] == 2'b00)
            mRegs[regAddr >> 2] = regWrData;
          if (cancelIn) mRem = 0;
          else if (startIn) begin
            mState = 1; mIdx = 0; mFirst = 1; mFptr = mRegs[5];
          end
        end
        1: begin
          if (cancelIn) begin
            mState = 0; mRem = 0; mSkip = 0;
          end else if (memAck) begin
            mShadow[mIdx] = memRdData;
            if (mIdx == 7) begin
              for (int k = 0; k < 8; k++) mRegs[k] = mShadow[k];
              sz = int'(mShadow[4][23:0]);
              mSkip = (sz == 32'h00FF_FFFF);
              mRem = mSkip ? 0 : sz + 1;
              if (mFirst) evtN = 1'b1;
              mFirst = 0;
              mState = 2;
            end else mIdx++;
          end
        end
        default: begin
          if (cancelIn) begin
            mState = 0; mRem = 0; mSkip = 0;
          end else begin
            last = mSkip || mRem <= BB;
            if (!mSkip) begin
              bytes = (mRem < BB) ? mRem : BB;
              if (mRegs[0][8])  mRegs[2] = mRegs[2] + BB;
              if (mRegs[0][12]) mRegs[3] = mRegs[3] + BB;
              mRem = mRem - bytes;
            end
            if (last) begin
              evtN = 1'b1; mRem = 0;
              if (mRegs[5] == 32'h0) mState = 0;
              else begin mState = 1; mIdx = 0; mFptr = mRegs[5]; end
            end
          end
        end
      endcase
      mEvt = evtN;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit cancelIn, expBeat;
    int expBytes;
    #1;
    if (rstN) begin
      cancelIn = regWrEn && regAddr == 6'h1C && regWrData[20];
      expBeat  = (mState == 2) && !mSkip && !cancelIn;
      expBytes = (mRem < BB) ? mRem : BB;
      check(memReq == (mState == 1), "R2 memReq", 32'(memReq), 32'(mState == 1));
      if (mState == 1)
        check(memAddr == mFptr + 32'(4 * mIdx), "R2 memAddr", memAddr, mFptr + 32'(4 * mIdx));
      check(beatValid == expBeat, "R5 beatValid", 32'(beatValid), 32'(expBeat));
      if (expBeat) begin
        check(beatRdAddr == mRegs[2], "R5 beatRdAddr", beatRdAddr, mRegs[2]);
        check(beatWrAddr == mRegs[3], "R5 beatWrAddr", beatWrAddr, mRegs[3]);
        check(32'(beatBytes) == 32'(expBytes), "R5 beatBytes", 32'(beatBytes), 32'(expBytes));
      end
      check(evtPulse == mEvt, "R4 R6 evtPulse", 32'(evtPulse), 32'(mEvt));
      check(regRdData == modelRead(regRdAddr),
            (regRdAddr == 6'h30) ? "R8 active size" : "R3 register read",
            regRdData, modelRead(regRdAddr));
      if (beatValid) begin beatCnt++; byteSum += int'(beatBytes); end
      if (evtPulse) evtCnt++;
      if (memReq && memAck && memAddr == 32'h300) headFetch++;
      if (memReq && memAddr[31:8] == 24'h6) badFetch++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog: actual=%0d expected=0 (hung run)", testCnt);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check(memReq == 1'b0, "R1 memReq", 32'(memReq), 32'h0);
    check(beatValid == 1'b0, "R1 beatValid", 32'(beatValid), 32'h0);
    check(evtPulse == 1'b0, "R1 evtPulse", 32'(evtPulse), 32'h0);
    check(regRdData == 32'h00FF_FFFF, "R1 active size", regRdData, 32'h00FF_FFFF);

    // single descriptor, 9 bytes, both addresses step
    putDesc(32'h100, 32'h0000_1122, 32'h1000, 32'h2000, 32'd8, 32'h0);
    beatCnt = 0; byteSum = 0; evtCnt = 0;
    regWrite(6'h14, 32'h100);
    regWrite(6'h1C, 32'h10);
    waitIdle();
    check(beatCnt == 3, "R5 beat count", 32'(beatCnt), 32'd3);
    check(byteSum == 9, "R5 byte total", 32'(byteSum), 32'd9);
    check(evtCnt == 2, "R4 R6 event count", 32'(evtCnt), 32'd2);
    regRead(6'h08, v); check(v == 32'h100C, "R5 read addr step", v, 32'h100C);
    regRead(6'h10, v); check(v == 32'd8, "R3 size word", v, 32'd8);
    regRead(6'h04, v); check(v == 32'h5, "R3 word 1", v, 32'h5);
    regRead(6'h2C, v); check(v == 32'h0, "R8 unused offset", v, 32'h0);

    // chain of three with a reserved-size node in the middle, stalled acks
    putDesc(32'h200, 32'h0000_0100, 32'h3000, 32'h4000, 32'd15, 32'h240);
    putDesc(32'h240, 32'h0000_1100, 32'h3800, 32'h4800, 32'h00FF_FFFF, 32'h280);
    putDesc(32'h280, 32'h0000_0000, 32'h5000, 32'h6000, 32'd5, 32'h0);
    ackMode = 1;
    beatCnt = 0; byteSum = 0; evtCnt = 0;
    regWrite(6'h14, 32'h200);
    regWrite(6'h1C, 32'h10);
    waitIdle();
    check(beatCnt == 6, "R9 beats skip reserved", 32'(beatCnt), 32'd6);
    check(byteSum == 22, "R9 byte total", 32'(byteSum), 32'd22);
    check(evtCnt == 4, "R6 chain events", 32'(evtCnt), 32'd4);
    regRead(6'h08, v); check(v == 32'h5000, "R5 no read step", v, 32'h5000);
    regRead(6'h0C, v); check(v == 32'h6000, "R5 no write step", v, 32'h6000);

    // ring of two nodes, then cancel while running
    putDesc(32'h300, 32'h0000_1100, 32'h8000, 32'h9000, 32'd7, 32'h340);
    putDesc(32'h340, 32'h0000_1100, 32'hA000, 32'hB000, 32'd3, 32'h300);
    headFetch = 0;
    regWrite(6'h14, 32'h300);
    regWrite(6'h1C, 32'h10);
    repeat (300) @(negedge clk);
    check(headFetch >= 3, "R7 ring repeats", 32'(headFetch), 32'd3);
    regWrite(6'h1C, 32'h0010_0000);
    e0 = evtCnt;
    repeat (20) @(negedge clk);
    #2;
    check(memReq == 1'b0, "R10 no read after cancel", 32'(memReq), 32'h0);
    check(evtCnt == e0, "R10 no event after cancel", 32'(evtCnt), 32'(e0));

    // cancel partway through a fetch
    putDesc(32'h400, 32'h0000_1100, 32'h5555, 32'h6666, 32'd3, 32'h0);
    regWrite(6'h08, 32'hAAAA_0000);
    regWrite(6'h14, 32'h400);
    regWrite(6'h1C, 32'h10);
    repeat (3) @(negedge clk);
    e0 = evtCnt;
    regWrite(6'h1C, 32'h0010_0000);
    repeat (4) @(negedge clk);
    regRead(6'h08, v); check(v == 32'hAAAA_0000, "R10 partial discarded", v, 32'hAAAA_0000);
    regRead(6'h14, v); check(v == 32'h400, "R10 node kept", v, 32'h400);
    check(evtCnt == e0, "R10 no event on fetch cancel", 32'(evtCnt), 32'(e0));

    // writes while busy are ignored
    ackMode = 0;
    badFetch = 0;
    putDesc(32'h500, 32'h0000_1100, 32'h7000, 32'h7800, 32'd63, 32'h0);
    regWrite(6'h14, 32'h500);
    regWrite(6'h1C, 32'h10);
    repeat (12) @(negedge clk);
    regWrite(6'h14, 32'h600);
    regWrite(6'h08, 32'h0000_BEEF);
    regWrite(6'h1C, 32'h10);
    waitIdle();
    regRead(6'h14, v); check(v == 32'h0, "R11 node write ignored", v, 32'h0);
    regRead(6'h08, v); check(v == 32'h7040, "R11 addr write ignored", v, 32'h7040);
    check(badFetch == 0, "R11 no fetch from written node", 32'(badFetch), 32'h0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule